// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives a single active-low system reset line from three independent causes: the power-on condition, a low-supply comparator flag, and the expiry of a watchdog timer. Any one cause holding is enough to keep reset asserted. The supply-related hold always lasts a fixed settling period after its cause has gone away, so that rails and oscillators can settle before software runs.

The watchdog is serviced by pulses on the chip-select line of the serial port that shares the supervisor. No separate kick strobe exists. Its period comes from a two-bit selection code. A newly written code waits until the end of the next command before it is used, and one code turns the watchdog off. All times are counted in units of an external time-base tick. Each duration is a parameter, so a bench can shrink them.

Top module: `sys_reset_supervisor`

## Requirements
- R1: While `por_n` is low, `reset_n` is low. After `por_n` rises, `reset_n` stays low for exactly `PUR_TICKS` ticks and then goes high.
- R2: `reset_n` goes low on the clock edge after `vlow` is seen high, and it stays low while `vlow` is high. After `vlow` clears, `reset_n` goes high only once `PUR_TICKS` more ticks have passed.
- R3: The selection code in use after power-on is 2'b11, which means the watchdog is off. While that code is in use, no timeout ever occurs.
- R4: Code 2'b00 selects a timeout of `WD_TICKS_LONG` ticks, 2'b01 selects `WD_TICKS_MID` ticks, and 2'b10 selects `WD_TICKS_SHORT` ticks. Each timeout is counted from the last restart of the watchdog count.
- R5: The value on `wd_sel` is taken into use only on a clock where `cmd_done` is high, and that same clock restarts the watchdog count. A changed `wd_sel` with no `cmd_done` has no effect.
- R6: `cs_n` held low for at least `CS_MIN_CLKS` clock edges restarts the watchdog count on the edge where `cs_n` is seen high again. A shorter low pulse is ignored.
- R7: On a watchdog timeout, `reset_n` is held low for `RST_TICKS` ticks. After that it is released, and the watchdog count starts again from zero.
- R8: The watchdog count is held at zero whenever `reset_n` is low. A chip-select pulse during a reset hold does not shorten that hold.
- R9: Every duration advances only on clocks where `tick` is high. With `tick` held low, a reset hold does not end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on indication; low clears all state and asserts reset |
| tick | input | 1 | Time-base enable; one pulse per time unit |
| vlow | input | 1 | Low-supply comparator flag, active high |
| cs_n | input | 1 | Serial-port chip-select, active low; pulses service the watchdog |
| wd_sel | input | 2 | Requested watchdog selection code |
| cmd_done | input | 1 | One-clock pulse at the end of a read or write command |
| reset_n | output | 1 | System reset, active low, registered |

## Verification
The case that is hardest to reach from the ports is a chip-select pulse that arrives while the watchdog reset hold is already running. The stimulus first has to let a timeout happen. It then has to catch the low phase of `reset_n` and place a full-width pulse inside that phase. The bench does this by driving `cs_n` from inside the loop that measures the length of the low phase, and it checks that the measured hold is still `RST_TICKS`. It also checks that the timeout following the release is counted from zero. Constrained random pulse gaps and widths are drawn for each enabled code and are kept just inside the timeout. A glitch of width `CS_MIN_CLKS-1` placed inside a measured window shows that short pulses leave the schedule unchanged.

// File: rtl/rs_sup_pkg.sv
package rs_sup_pkg;

  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_code_e;

  // Timeout length in ticks for a selection code; zero means disabled.
  function automatic int unsigned wd_limit(input wd_code_e code,
                                           input int unsigned t_long,
                                           input int unsigned t_mid,
                                           input int unsigned t_short);
    int unsigned r;
    case (code)
      WD_LONG:  r = t_long;
      WD_MID:   r = t_mid;
      WD_SHORT: r = t_short;
      default:  r = 0;
    endcase
    return r;
  endfunction

  // True when a code keeps the watchdog running.
  function automatic logic wd_enabled(input wd_code_e code);
    return code != WD_OFF;
  endfunction

endpackage

// File: rtl/rs_hold_timer.sv
// Tick-driven down counter: a load request reloads it, and it reads busy
// while nonzero.
module rs_hold_timer #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned LOAD_TICKS = 200,
  parameter bit          START_BUSY = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic load,
  input  logic tick,
  output logic busy
);
  localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD_TICKS);
  localparam logic [CNT_W-1:0] INIT_V = START_BUSY ? LOAD_V : '0;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt <= INIT_V;
    end else if (load) begin
      cnt <= LOAD_V;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/rs_cs_qual.sv
// Qualifies chip-select low pulses by width; emits a kick on the release edge.
module rs_cs_qual #(
  parameter int unsigned CS_MIN_CLKS = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic cs_n,
  output logic kick
);
  localparam int unsigned LW_W = (CS_MIN_CLKS < 2) ? 1 : $clog2(CS_MIN_CLKS + 1);
  localparam logic [LW_W-1:0] LW_SAT = LW_W'(CS_MIN_CLKS);

  logic            cs_prev;
  logic [LW_W-1:0] low_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cs_prev <= 1'b1;
      low_run <= '0;
    end else begin
      cs_prev <= cs_n;
      if (cs_n) begin
        low_run <= '0;
      end else if (low_run != LW_SAT) begin
        low_run <= low_run + 1'b1;
      end
    end
  end

  assign kick = cs_n && !cs_prev && (low_run >= LW_SAT);
endmodule

// File: rtl/rs_wdt_core.sv
// Watchdog: latched selection code, tick counter and expiry detect.
module rs_wdt_core
  import rs_sup_pkg::*;
#(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned WD_TICKS_LONG  = 1400,
  parameter int unsigned WD_TICKS_MID   = 600,
  parameter int unsigned WD_TICKS_SHORT = 200
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             tick,
  input  logic             hold,
  input  logic             kick,
  input  logic             cmd_done,
  input  logic [1:0]       sel_in,
  output logic             expire,
  output logic [1:0]       act_code,
  output logic [CNT_W-1:0] cnt
);
  wd_code_e     act_q;
  int unsigned  lim;
  logic         run;
  logic         at_end;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      act_q <= WD_OFF;
    end else if (cmd_done) begin
      act_q <= wd_code_e'(sel_in);
    end
  end

  assign lim    = wd_limit(act_q, WD_TICKS_LONG, WD_TICKS_MID, WD_TICKS_SHORT);
  assign run    = wd_enabled(act_q) && !hold;
  assign at_end = ({{(32-CNT_W){1'b0}}, cnt} == (lim - 1));
  assign expire = run && tick && at_end;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt <= '0;
    end else if (!run || kick || cmd_done) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= at_end ? '0 : cnt + 1'b1;
    end
  end

  assign act_code = act_q;
endmodule

// File: rtl/sys_reset_supervisor.sv
module sys_reset_supervisor #(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned PUR_TICKS      = 200,
  parameter int unsigned RST_TICKS      = 200,
  parameter int unsigned WD_TICKS_LONG  = 1400,
  parameter int unsigned WD_TICKS_MID   = 600,
  parameter int unsigned WD_TICKS_SHORT = 200,
  parameter int unsigned CS_MIN_CLKS    = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tick,
  input  logic       vlow,
  input  logic       cs_n,
  input  logic [1:0] wd_sel,
  input  logic       cmd_done,
  output logic       reset_n
);
  // Named internal events, brought out for the checker.
  logic             pur_busy;
  logic             wdr_busy;
  logic             any_src;
  logic             cs_kick;
  logic             wd_expire;
  logic [1:0]       wd_act;
  logic [CNT_W-1:0] wd_cnt;

  rs_hold_timer #(
    .CNT_W(CNT_W), .LOAD_TICKS(PUR_TICKS), .START_BUSY(1'b1)
  ) u_pur (
    .clk(clk), .por_n(por_n), .load(vlow), .tick(tick), .busy(pur_busy)
  );

  rs_hold_timer #(
    .CNT_W(CNT_W), .LOAD_TICKS(RST_TICKS), .START_BUSY(1'b0)
  ) u_wdr (
    .clk(clk), .por_n(por_n), .load(wd_expire), .tick(tick), .busy(wdr_busy)
  );

  rs_cs_qual #(
    .CS_MIN_CLKS(CS_MIN_CLKS)
  ) u_csq (
    .clk(clk), .por_n(por_n), .cs_n(cs_n), .kick(cs_kick)
  );

  rs_wdt_core #(
    .CNT_W(CNT_W),
    .WD_TICKS_LONG(WD_TICKS_LONG),
    .WD_TICKS_MID(WD_TICKS_MID),
    .WD_TICKS_SHORT(WD_TICKS_SHORT)
  ) u_wdt (
    .clk(clk), .por_n(por_n), .tick(tick), .hold(any_src), .kick(cs_kick),
    .cmd_done(cmd_done), .sel_in(wd_sel), .expire(wd_expire),
    .act_code(wd_act), .cnt(wd_cnt)
  );

  assign any_src = vlow || pur_busy || wdr_busy;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      reset_n <= 1'b0;
    end else begin
      reset_n <= !any_src;
    end
  end
endmodule

// File: rtl/rs_sup_chk.sv
module rs_sup_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             por_n,
  input logic             vlow,
  input logic             cmd_done,
  input logic             reset_n,
  input logic             pur_busy,
  input logic             wd_expire,
  input logic [1:0]       wd_act,
  input logic [CNT_W-1:0] wd_cnt
);
  // R1
  pur_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    pur_busy |=> !reset_n);

  // R2
  vlow_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    vlow |=> !reset_n);

  // R3
  off_no_expire_chk: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |-> (wd_act != 2'b11));

  // R5
  cfg_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
    !cmd_done |=> $stable(wd_act));

  // R7
  expire_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    wd_expire |=> ##1 !reset_n);

  // R8
  cnt_zero_in_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    !reset_n |-> (wd_cnt == '0));
endmodule

bind sys_reset_supervisor rs_sup_chk #(.CNT_W(CNT_W)) u_sup_chk (
  .clk(clk), .por_n(por_n), .vlow(vlow), .cmd_done(cmd_done),
  .reset_n(reset_n), .pur_busy(pur_busy), .wd_expire(wd_expire),
  .wd_act(wd_act), .wd_cnt(wd_cnt)
);

// File: tb/tb_sys_reset_supervisor.sv
`timescale 1ns/1ps
module tb_sys_reset_supervisor;
  localparam int unsigned CNT_W  = 12;
  localparam int unsigned PUR    = 10;
  localparam int unsigned RSTT   = 8;
  localparam int unsigned TLONG  = 40;
  localparam int unsigned TMID   = 24;
  localparam int unsigned TSHORT = 12;
  localparam int unsigned CSMIN  = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0, tick = 1'b1, vlow = 1'b0, cs_n = 1'b1, cmd_done = 1'b0;
  logic [1:0] wd_sel = 2'b11;
  logic reset_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sys_reset_supervisor #(
    .CNT_W(CNT_W), .PUR_TICKS(PUR), .RST_TICKS(RSTT),
    .WD_TICKS_LONG(TLONG), .WD_TICKS_MID(TMID), .WD_TICKS_SHORT(TSHORT),
    .CS_MIN_CLKS(CSMIN)
  ) dut (
    .clk(clk), .por_n(por_n), .tick(tick), .vlow(vlow), .cs_n(cs_n),
    .wd_sel(wd_sel), .cmd_done(cmd_done), .reset_n(reset_n)
  );

  // Expected timeout in ticks for a code, restated from R3/R4.
  function automatic int exp_limit(input logic [1:0] c);
    if (c == 2'b00) return TLONG;
    if (c == 2'b01) return TMID;
    if (c == 2'b10) return TSHORT;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count falling edges with reset_n high, starting at the current one.
  task automatic count_high(input bit glitch, output int n);
    n = 0;
    for (int i = 0; i < 4 * TLONG + 40; i++) begin
      if (!reset_n) break;
      n++;
      if (glitch && i == 2) cs_n = 1'b0;
      if (glitch && i == 2 + CSMIN - 1) cs_n = 1'b1;
      @(negedge clk);
    end
  endtask

  // Count falling edges with reset_n low; optionally a full pulse inside.
  task automatic count_low(input bit wait_first, input bit kick_in, output int n);
    n = 0;
    if (wait_first) @(negedge clk);
    for (int i = 0; i < 4 * TLONG + 40; i++) begin
      if (reset_n) break;
      n++;
      if (kick_in && i == 0) cs_n = 1'b0;
      if (kick_in && i == CSMIN + 1) cs_n = 1'b1;
      @(negedge clk);
    end
    cs_n = 1'b1;
  endtask

  task automatic pulse_cmd(input logic [1:0] c);
    wd_sel = c;
    cmd_done = 1'b1;
    @(negedge clk);
    cmd_done = 1'b0;
  endtask

  task automatic kick(input int w);
    cs_n = 1'b0;
    repeat (w) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic stay_high(input int cyc, input string req);
    int lows = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (!reset_n) lows++;
    end
    chk(lows == 0, req, lows, 0);
  endtask

  initial begin
    int n;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(reset_n == 1'b0, "R1 reset state", int'(reset_n), 0);

    // R9: release with tick stopped, hold must not end
    tick = 1'b0;
    por_n = 1'b1;
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (reset_n) n++;
    end
    chk(n == 0, "R9 no tick no release", n, 0);
    tick = 1'b1;
    count_low(1'b1, 1'b0, n);
    chk(n == PUR, "R1 power-up hold", n, PUR);

    // R3 default off
    stay_high(3 * TLONG, "R3 default disabled");
    // R5 new code not used without cmd_done
    wd_sel = 2'b10;
    stay_high(3 * TLONG, "R5 code ignored before cmd_done");

    pulse_cmd(2'b10);
    count_high(1'b0, n);
    chk(n == exp_limit(2'b10) + 1, "R4 R5 short code timeout", n, exp_limit(2'b10) + 1);
    count_low(1'b0, 1'b0, n);
    chk(n == RSTT, "R7 reset hold", n, RSTT);
    count_high(1'b0, n);
    chk(n == exp_limit(2'b10), "R7 count restarts from zero", n, exp_limit(2'b10));
    count_low(1'b0, 1'b0, n);

    pulse_cmd(2'b01);
    count_high(1'b0, n);
    chk(n == exp_limit(2'b01) + 1, "R4 mid code timeout", n, exp_limit(2'b01) + 1);
    count_low(1'b0, 1'b1, n);
    chk(n == RSTT, "R8 pulse in reset does not shorten", n, RSTT);
    count_high(1'b0, n);
    chk(n == exp_limit(2'b01), "R8 count zero after reset", n, exp_limit(2'b01));
    count_low(1'b0, 1'b0, n);

    pulse_cmd(2'b00);
    count_high(1'b0, n);
    chk(n == exp_limit(2'b00) + 1, "R4 long code timeout", n, exp_limit(2'b00) + 1);
    count_low(1'b0, 1'b0, n);

    // R6 full kick restarts, glitch ignored
    repeat (10) @(negedge clk);
    kick(CSMIN);
    count_high(1'b1, n);
    chk(n == exp_limit(2'b00) + 1, "R6 kick restarts, short pulse ignored", n,
        exp_limit(2'b00) + 1);
    count_low(1'b0, 1'b0, n);

    // R2 low supply
    repeat (5) @(negedge clk);
    vlow = 1'b1;
    @(negedge clk);
    chk(reset_n == 1'b0, "R2 low supply asserts reset", int'(reset_n), 0);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (reset_n) n++;
    end
    chk(n == 0, "R2 held while flag high", n, 0);
    vlow = 1'b0;
    count_low(1'b1, 1'b0, n);
    chk(n == PUR, "R2 release after settling period", n, PUR);
    count_high(1'b0, n);
    chk(n == exp_limit(2'b00), "R8 watchdog restarts after supply hold", n, exp_limit(2'b00));
    count_low(1'b0, 1'b0, n);

    // R3 turn off again
    pulse_cmd(2'b11);
    stay_high(3 * TLONG, "R3 code 11 disables");

    // Random kick gaps kept inside the timeout
    for (int r = 0; r < 6; r++) begin
      logic [1:0] c;
      int lim, lows;
      c = 2'($urandom_range(0, 2));
      lim = exp_limit(c);
      pulse_cmd(c);
      lows = 0;
      for (int k = 0; k < 15; k++) begin
        int g, w;
        g = int'($urandom_range(0, lim - CSMIN - 3));
        w = int'($urandom_range(CSMIN, CSMIN + 1));
        for (int j = 0; j < g; j++) begin
          if (!reset_n) lows++;
          @(negedge clk);
        end
        cs_n = 1'b0;
        for (int j = 0; j < w; j++) begin
          if (!reset_n) lows++;
          @(negedge clk);
        end
        cs_n = 1'b1;
        if (!reset_n) lows++;
        @(negedge clk);
      end
      chk(lows == 0, "R6 random in-time kicks keep reset high", lows, 0);
      pulse_cmd(2'b11);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule